// File: doc/BRIEF.md
# Amplifier Trim Calibration Sequencer

This block closes a measure, decide and adjust loop around one amplifier stage. It owns two 7-bit trim codes, one for offset and one for gain. It steers the analog routing: stage power, stage input source, output switch, ADC power, test-voltage DAC power and the select of the shared ADC input mux. It reads back conversions from the shared 8-bit ADC. A run calibrates offset first, using a zero-level test voltage, and gain second, using a non-zero test voltage. In each phase the block waits a settling count after every trim update, takes one conversion, and moves the trim code one step toward a target window. The phase ends when a conversion lands inside the window.

A run starts by itself once after reset, again whenever a programmable idle period expires, and whenever `start` is pulsed while the block is idle. At the end of every run the routing goes back to normal mode and the block reports either done or fail. The trim codes are kept between runs, so a later run starts from the last result.

Top module: `cal_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the stage is off (`stage_run`=0), routing is in normal mode, `mux_sel`=0, both trim codes are 64, and `busy`, `done` and `fail` are 0.
- R2: A run launches with no stimulus on the first idle cycle after reset. It also launches when `start`=1 while idle, and after PERIOD consecutive idle cycles. `busy` is 1 from launch until the run ends.
- R3: Whenever `busy`=0, routing is normal: `in_sel_cal`, `out_sw_close`, `adc_run` and `vref_dac_run` are all 0.
- R4: `stage_run` becomes 1 one cycle before the test voltage is first routed to the stage input. Once set, it stays 1.
- R5: `mux_sel` equals CAL_PORT (1) while the stage is routed for calibration and PARK_PORT (0) otherwise. It never takes the value 2'b11.
- R6: The offset phase runs before the gain phase. The offset phase drives `test_code`=OFS_TEST_CODE and the gain phase drives GAIN_TEST_CODE. After every trim update, no conversion is accepted until SETTLE_CYC cycles have passed.
- R7: A conversion below the window [target-WIN_TOL, target+WIN_TOL] raises the phase's trim code by 1. A conversion above the window lowers it by 1. Codes saturate at 0 and 127 and never wrap.
- R8: If the first conversion of a phase lies inside the window, that trim code is left unchanged.
- R9: After MAX_ITER (128) out-of-window conversions in one phase, the run fails. The trim code keeps its last value, any remaining phase is skipped, and routing returns to normal.
- R10: After a successful run `done`=1 and `fail`=0. After a failed run `fail`=1 and `done`=0. Both hold until the next launch, and they are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, taken only while idle |
| adc_valid | input | 1 | Conversion result present on adc_data |
| adc_data | input | ADC_W | Conversion result |
| stage_run | output | 1 | Stage power control, 0 = stage off |
| in_sel_cal | output | 1 | Stage input source: 1 = test voltage, 0 = signal |
| out_sw_close | output | 1 | Closes the switch from stage output to ADC mux |
| adc_run | output | 1 | ADC power, 0 = powered down |
| vref_dac_run | output | 1 | Test-voltage DAC power, 0 = powered down |
| mux_sel | output | 2 | ADC input mux select |
| test_code | output | VC_W | Test-voltage DAC code |
| gain_trim | output | TRIM_W | Gain trim DAC code |
| ofs_trim | output | TRIM_W | Offset trim DAC code |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run ended with both phases in window |
| fail | output | 1 | Last run hit the iteration limit |

## Verification
The bench models the stage as a linear response with a three-cycle lag. It sweeps offset and gain errors across both polarities, from zero through small values to values beyond the trim range. The zero case separates a sequencer that leaves a correct setting alone from one that dithers. Small errors check the step direction and the exact stopping code at the window edge. Errors too large to correct must end in saturation with a graceful fail rather than a wrap. Because trim codes carry over between runs, consecutive sweep points also test starting from codes other than mid-scale. The lag in the model makes a sequencer that skips its settling wait overshoot, which changes the final code.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_OFS_SETTLE,
        ST_OFS_MEAS,
        ST_GAIN_SETTLE,
        ST_GAIN_MEAS,
        ST_FINISH
    } cal_state_e;
endpackage

// File: rtl/cal_sat_trim.sv
module cal_sat_trim #(
    parameter int W    = 7,
    parameter int INIT = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] TOP  = '1;
    localparam logic [W-1:0] SEED = INIT[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= SEED;
        end else if (step_up && code != TOP) begin
            code <= code + 1'b1;
        end else if (step_dn && code != '0) begin
            code <= code - 1'b1;
        end
    end
endmodule

// File: rtl/cal_window.sv
module cal_window #(
    parameter int W   = 8,
    parameter int TOL = 2
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] target,
    output logic         below,
    output logic         above
);
    localparam logic [W:0] TOL_X = TOL[W:0];

    always_comb begin
        below = ({1'b0, sample} + TOL_X) < {1'b0, target};
        above = {1'b0, sample} > ({1'b0, target} + TOL_X);
    end
endmodule

// File: rtl/cal_timer.sv
module cal_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic fire
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign fire = count_en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!count_en || fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_seq_pkg::*;
#(
    parameter int ADC_W          = 8,
    parameter int TRIM_W         = 7,
    parameter int VC_W           = 8,
    parameter int SETTLE_CYC     = 16,
    parameter int PERIOD         = 100000,
    parameter int MAX_ITER       = 128,
    parameter int WIN_TOL        = 2,
    parameter int OFS_TARGET     = 128,
    parameter int GAIN_TARGET    = 160,
    parameter int OFS_TEST_CODE  = 0,
    parameter int GAIN_TEST_CODE = 200,
    parameter int CAL_PORT       = 1,
    parameter int PARK_PORT      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              adc_valid,
    input  logic [ADC_W-1:0]  adc_data,
    output logic              stage_run,
    output logic              in_sel_cal,
    output logic              out_sw_close,
    output logic              adc_run,
    output logic              vref_dac_run,
    output logic [1:0]        mux_sel,
    output logic [VC_W-1:0]   test_code,
    output logic [TRIM_W-1:0] gain_trim,
    output logic [TRIM_W-1:0] ofs_trim,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int IW = $clog2(MAX_ITER + 1);
    localparam logic [SW-1:0]    SETTLE_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [IW-1:0]    ITER_LAST   = IW'(MAX_ITER - 1);
    localparam logic [ADC_W-1:0] OFS_TGT     = ADC_W'(OFS_TARGET);
    localparam logic [ADC_W-1:0] GAIN_TGT    = ADC_W'(GAIN_TARGET);
    localparam int TRIM_MID = 1 << (TRIM_W - 1);

    cal_state_e     state_q, state_d;
    logic [SW-1:0]  settle_q;
    logic [IW-1:0]  iter_q;
    logic           launch_pend_q;
    logic           tmr_fire;
    logic           below, above, miss, last_try, in_meas, gain_ph, take;
    logic           launch, route_d;
    logic [ADC_W-1:0] target;

    assign in_meas  = (state_q == ST_OFS_MEAS) || (state_q == ST_GAIN_MEAS);
    assign gain_ph  = (state_q == ST_GAIN_MEAS);
    assign target   = gain_ph ? GAIN_TGT : OFS_TGT;
    assign miss     = below || above;
    assign last_try = (iter_q == ITER_LAST);
    assign take     = in_meas && adc_valid;
    assign launch   = (state_q == ST_IDLE) && (state_d == ST_PWRUP);

    cal_window #(.W(ADC_W), .TOL(WIN_TOL)) win_i (
        .sample (adc_data),
        .target (target),
        .below  (below),
        .above  (above)
    );

    cal_timer #(.PERIOD(PERIOD)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (state_q == ST_IDLE),
        .fire     (tmr_fire)
    );

    cal_sat_trim #(.W(TRIM_W), .INIT(TRIM_MID)) ofs_trim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (take && !gain_ph && below && !last_try),
        .step_dn (take && !gain_ph && above && !last_try),
        .code    (ofs_trim)
    );

    cal_sat_trim #(.W(TRIM_W), .INIT(TRIM_MID)) gain_trim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (take && gain_ph && below && !last_try),
        .step_dn (take && gain_ph && above && !last_try),
        .code    (gain_trim)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (launch_pend_q || start || tmr_fire) state_d = ST_PWRUP;
            ST_PWRUP:       state_d = ST_OFS_SETTLE;
            ST_OFS_SETTLE:  if (settle_q == SETTLE_LAST) state_d = ST_OFS_MEAS;
            ST_OFS_MEAS:
                if (adc_valid) begin
                    if (!miss)         state_d = ST_GAIN_SETTLE;
                    else if (last_try) state_d = ST_FINISH;
                    else               state_d = ST_OFS_SETTLE;
                end
            ST_GAIN_SETTLE: if (settle_q == SETTLE_LAST) state_d = ST_GAIN_MEAS;
            ST_GAIN_MEAS:
                if (adc_valid) begin
                    if (!miss || last_try) state_d = ST_FINISH;
                    else                   state_d = ST_GAIN_SETTLE;
                end
            ST_FINISH:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q      <= '0;
            iter_q        <= '0;
            launch_pend_q <= 1'b1;
        end else begin
            settle_q <= (state_d == state_q) ? settle_q + 1'b1 : '0;
            if (state_q == ST_IDLE) launch_pend_q <= 1'b0;
            if (state_q == ST_PWRUP || (state_q == ST_OFS_MEAS && state_d == ST_GAIN_SETTLE))
                iter_q <= '0;
            else if (take && miss)
                iter_q <= iter_q + 1'b1;
        end
    end

    assign route_d = (state_d == ST_OFS_SETTLE) || (state_d == ST_OFS_MEAS) ||
                     (state_d == ST_GAIN_SETTLE) || (state_d == ST_GAIN_MEAS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_run    <= 1'b0;
            in_sel_cal   <= 1'b0;
            out_sw_close <= 1'b0;
            adc_run      <= 1'b0;
            vref_dac_run <= 1'b0;
            mux_sel      <= 2'(PARK_PORT);
            test_code    <= '0;
            busy         <= 1'b0;
            done         <= 1'b0;
            fail         <= 1'b0;
        end else begin
            stage_run    <= stage_run || (state_d == ST_PWRUP);
            in_sel_cal   <= route_d;
            out_sw_close <= route_d;
            adc_run      <= route_d;
            vref_dac_run <= route_d;
            mux_sel      <= route_d ? 2'(CAL_PORT) : 2'(PARK_PORT);
            if (state_d == ST_GAIN_SETTLE || state_d == ST_GAIN_MEAS)
                test_code <= VC_W'(GAIN_TEST_CODE);
            else
                test_code <= VC_W'(OFS_TEST_CODE);
            busy <= (state_d != ST_IDLE);
            if (launch) begin
                done <= 1'b0;
                fail <= 1'b0;
            end else begin
                if (take && miss && last_try) fail <= 1'b1;
                if (state_q == ST_FINISH && !fail) done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
    parameter int TRIM_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stage_run,
    input logic              in_sel_cal,
    input logic              out_sw_close,
    input logic              adc_run,
    input logic              vref_dac_run,
    input logic [1:0]        mux_sel,
    input logic [TRIM_W-1:0] gain_trim,
    input logic [TRIM_W-1:0] ofs_trim,
    input logic              busy,
    input logic              done,
    input logic              fail
);
    localparam logic [TRIM_W-1:0] TOP = '1;

    AST_NORMAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(in_sel_cal || out_sw_close || adc_run || vref_dac_run)); // R3

    AST_POWER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sel_cal) |-> $past(stage_run)); // R4

    AST_STAGE_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stage_run) |-> stage_run); // R4

    AST_MUX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sel != 2'b11); // R5

    AST_NO_OFS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ofs_trim) == TOP |-> ofs_trim != '0) and
        ($past(ofs_trim) == '0 |-> ofs_trim != TOP)); // R7

    AST_NO_GAIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gain_trim) == TOP |-> gain_trim != '0) and
        ($past(gain_trim) == '0 |-> gain_trim != TOP)); // R7

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R10
endmodule

bind cal_seq cal_seq_chk #(.TRIM_W(TRIM_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .stage_run    (stage_run),
    .in_sel_cal   (in_sel_cal),
    .out_sw_close (out_sw_close),
    .adc_run      (adc_run),
    .vref_dac_run (vref_dac_run),
    .mux_sel      (mux_sel),
    .gain_trim    (gain_trim),
    .ofs_trim     (ofs_trim),
    .busy         (busy),
    .done         (done),
    .fail         (fail)
);

// File: tb/cal_seq_tb_top.sv
module cal_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int PER        = 400;
    localparam int TOL        = 2;
    localparam int OFS_T      = 128;
    localparam int GAIN_T     = 160;
    localparam int OFS_TC     = 0;
    localparam int GAIN_TC    = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       adc_valid = 1'b0;
    logic [7:0] adc_data = '0;
    logic       stage_run, in_sel_cal, out_sw_close, adc_run, vref_dac_run;
    logic [1:0] mux_sel;
    logic [7:0] test_code;
    logic [6:0] gain_trim, ofs_trim;
    logic       busy, done, fail;

    int n_vec = 0;
    int n_bad = 0;
    int err_o = 0;
    int err_g = 0;
    int exp_o = 64;
    int exp_g = 64;
    int v_route = 0, v_mux = 0, v_order = 0, v_tcode = 0, v_seq = 0;
    int ho[3] = '{64, 64, 64};
    int hg[3] = '{64, 64, 64};
    logic prev_route = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_seq #(
        .SETTLE_CYC(SETTLE), .PERIOD(PER), .WIN_TOL(TOL),
        .OFS_TARGET(OFS_T), .GAIN_TARGET(GAIN_T),
        .OFS_TEST_CODE(OFS_TC), .GAIN_TEST_CODE(GAIN_TC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .adc_valid(adc_valid), .adc_data(adc_data),
        .stage_run(stage_run), .in_sel_cal(in_sel_cal),
        .out_sw_close(out_sw_close), .adc_run(adc_run),
        .vref_dac_run(vref_dac_run), .mux_sel(mux_sel),
        .test_code(test_code), .gain_trim(gain_trim), .ofs_trim(ofs_trim),
        .busy(busy), .done(done), .fail(fail)
    );

    function automatic int clamp8(int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // Stage model: reading follows the trim code with a three-cycle lag.
    always @(negedge clk) begin
        logic route;
        ho[2] = ho[1]; ho[1] = ho[0]; ho[0] = int'(ofs_trim);
        hg[2] = hg[1]; hg[1] = hg[0]; hg[0] = int'(gain_trim);
        route = in_sel_cal && out_sw_close && adc_run && vref_dac_run && (mux_sel == 2'd1);
        adc_valid <= route;
        if (int'(test_code) == GAIN_TC)
            adc_data <= 8'(clamp8(GAIN_T + err_g + hg[2] - 64));
        else
            adc_data <= 8'(clamp8(OFS_T + err_o + ho[2] - 64));
        if (rst_n) begin
            if (!busy && (in_sel_cal || out_sw_close || adc_run || vref_dac_run)) v_route++; // R3
            if (mux_sel == 2'b11 || (in_sel_cal != (mux_sel == 2'd1))) v_mux++;             // R5
            if (in_sel_cal && !stage_run) v_order++;                                         // R4
            if (in_sel_cal && int'(test_code) != OFS_TC && int'(test_code) != GAIN_TC) v_tcode++; // R6
            if (in_sel_cal && !prev_route && int'(test_code) != OFS_TC) v_seq++;             // R6
            prev_route = in_sel_cal;
        end
    end

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Arithmetic expectation for one phase: final code and fail flag.
    task automatic predict(input int e, input int c0, output int c, output bit f);
        int d;
        d = e + c0 - 64;
        f = 1'b0;
        c = c0;
        if (d > TOL) begin
            c = c0 - (d - TOL);
            if (c < 0) begin c = 0; f = 1'b1; end
        end else if (d < -TOL) begin
            c = c0 + (-TOL - d);
            if (c > 127) begin c = 127; f = 1'b1; end
        end
    endtask

    task automatic wait_run_end();
        int k;
        k = 0;
        while (!busy && k < 50) begin @(negedge clk); k++; end
        k = 0;
        while (busy && k < 6000) begin @(negedge clk); k++; end
        if (busy) begin
            n_vec++; n_bad++;
            $display("FAIL R2: run did not end, actual busy 1 expected 0");
        end
        @(negedge clk);
    endtask

    task automatic run_case(int eo, int eg, bit use_start);
        int co, cg;
        bit fo, fg;
        err_o = eo;
        err_g = eg;
        predict(eo, exp_o, co, fo);
        exp_o = co;
        fg = 1'b0;
        if (!fo) begin
            predict(eg, exp_g, cg, fg);
            exp_g = cg;
        end
        if (use_start) begin
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wait_run_end();
        check($sformatf("R7 offset trim eo=%0d", eo), int'(ofs_trim), exp_o);
        check($sformatf("R7 gain trim eg=%0d", eg), int'(gain_trim), exp_g);
        check("R9 fail flag", int'(fail), int'(fo || fg));
        check("R10 done flag", int'(done), int'(!(fo || fg)));
        check("R3 normal routing after run", int'(in_sel_cal || adc_run), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int idle;
        repeat (3) @(negedge clk);
        check("R1 stage off in reset", int'(stage_run), 0);
        check("R1 trims at mid-scale", int'(ofs_trim) * 256 + int'(gain_trim), 64 * 256 + 64);
        check("R1 status clear", int'({busy, done, fail}), 0);
        check("R1 mux parked", int'(mux_sel), 0);
        rst_n = 1'b1;
        // R2: first run launches on its own; R8: zero error leaves codes at 64.
        run_case(0, 0, 1'b0);
        check("R8 zero error offset unchanged", int'(ofs_trim), 64);
        check("R8 zero error gain unchanged", int'(gain_trim), 64);
        // Small in-window errors: R8, codes untouched.
        run_case(2, -2, 1'b1);
        // R7 / R9 sweep over both polarities and beyond range.
        for (int i = 0; i < 16; i++) begin
            run_case(-75 + 10 * i, 63 - 9 * i, 1'b1);
        end
        run_case(-200, 0, 1'b1);
        run_case(0, 200, 1'b1);
        run_case(0, 0, 1'b1);
        // R2: periodic relaunch after PER idle cycles.
        idle = 0;
        while (!busy && idle < 2 * PER) begin @(negedge clk); idle++; end
        check("R2 periodic launch early bound", int'(idle >= PER - 10), 1);
        check("R2 periodic launch late bound", int'(idle <= PER + 10), 1);
        wait_run_end();
        check("R3 routing monitor", v_route, 0);
        check("R4 power-before-route monitor", v_order, 0);
        check("R5 mux monitor", v_mux, 0);
        check("R6 test code monitor", v_tcode, 0);
        check("R6 offset phase first monitor", v_seq, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule